// File: doc/BRIEF.md
# DMA Address Hold Generator

This block produces the byte address for each beat on one side of a DMA transfer. A load pulse captures a start address, a byte count and a mode word. From then on, every accepted beat moves the address one step. Each beat carries one byte, so the count falls by one per beat.

With hold off, the address climbs linearly from the start address. With hold on, the address cycles through a window that starts at the start address. The window size is a power of two from 1 to 8 bytes, and the mode word gives it as a base-2 logarithm. A window of one byte keeps the address fixed, which suits a device port with a single address.

Two copies are used per channel: one for the source side and one for the destination side. A parameter picks which bits of the shared mode word each copy decodes.

Top module: `dma_addr_walker`

## Requirements
- R1: After reset, `addr_out` is 0 and both `beat_ready` and `done` are low.
- R2: Loading works as follows:
  - On the cycle after `ld_valid`, `addr_out` equals the loaded base.
  - `beat_ready` is high exactly when the loaded byte count is non-zero.
  - `done` is high exactly when the loaded byte count is zero.
- R3: With hold disabled, each accepted beat adds 1 to `addr_out`. The sum wraps modulo 2^AW.
- R4: With hold enabled and size code k, the window is N = 2^k bytes. The addresses run base, base+1, …, base+N-1 and then return to base, repeating.
- R5: Size code 0 with hold enabled keeps `addr_out` equal to the base for the whole transfer.
- R6: The address moves only on a cycle where `beat_valid` and `beat_ready` are both high. On any other cycle without a load, the address does not change.
- R7: Each accepted beat lowers the remaining count by one. When the count reaches zero:
  - `done` rises and `beat_ready` falls.
  - Further `beat_valid` pulses leave the address unchanged.
- R8: A load during a transfer restarts the window offset at zero from the new base. A load wins over a beat offered in the same cycle.
- R9: The hold enable and size code are captured at load time. Changes to `mode_word` during a transfer have no effect.
- R10: The mode word bit positions depend on the side:
  - The source side (SIDE=0) takes its enable from bit 12 and its size code from bits 15:14.
  - The destination side (SIDE=1) takes its enable from bit 13 and its size code from bits 17:16.
  - All other bits are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ld_valid | input | 1 | Load pulse: capture base, count and mode |
| ld_base | input | AW | Start address |
| ld_bytes | input | CW | Byte count (one byte per beat) |
| mode_word | input | 32 | Shared channel mode word, decoded per side |
| beat_valid | input | 1 | A beat is offered |
| beat_ready | output | 1 | Generator can accept a beat |
| addr_out | output | AW | Address for the current beat |
| done | output | 1 | Loaded transfer has run out of bytes |

## Verification
The case hardest to reach is a window wrap that meets a load, or meets a mid-transfer change of the mode word, on nearby cycles. This needs a hold transfer long enough to wrap several times while the stimulus interferes. The stimulus therefore runs windows of 2, 4 and 8 bytes with gapped `beat_valid` patterns. It reloads in the middle of a window and offers a beat in the same cycle as a load. It also flips every mode bit while hold transfers are running. Both a source-side and a destination-side instance take the same mode words, so a decode on the wrong bit position shows up as a diverging address.

// File: rtl/dma_hold_pkg.sv
package dma_hold_pkg;

  // Captured hold setting for one side of a transfer.
  typedef struct packed {
    logic       en;   // window mode active
    logic [1:0] lg;   // log2 of the window size in bytes
  } hold_cfg_t;

  localparam int SRC_EN_BIT  = 12;
  localparam int DST_EN_BIT  = 13;
  localparam int SRC_LG_LSB  = 14;
  localparam int DST_LG_LSB  = 16;

endpackage

// File: rtl/dma_hold_decode.sv
module dma_hold_decode
  import dma_hold_pkg::*;
#(
  parameter int SIDE = 0
) (
  input  logic [31:0] mode_word,
  output hold_cfg_t   cfg
);

  generate
    if (SIDE == 0) begin : g_src
      assign cfg.en = mode_word[SRC_EN_BIT];
      assign cfg.lg = mode_word[SRC_LG_LSB +: 2];
    end else begin : g_dst
      assign cfg.en = mode_word[DST_EN_BIT];
      assign cfg.lg = mode_word[DST_LG_LSB +: 2];
    end
  endgenerate

endmodule

// File: rtl/dma_hold_offset.sv
module dma_hold_offset
  import dma_hold_pkg::*;
#(
  parameter int OW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic          step,
  input  hold_cfg_t     cfg_in,
  output hold_cfg_t     cfg_q,
  output logic [OW-1:0] offset,
  output logic [OW-1:0] win_mask,
  output logic          wrap_evt,
  output logic          in_window
);

  logic [OW-1:0] off_q;

  function automatic logic [OW-1:0] mask_of(input logic [1:0] lg);
    return (OW'(1) << lg) - OW'(1);
  endfunction

  function automatic logic [OW-1:0] next_off(input logic [OW-1:0] cur,
                                             input hold_cfg_t c);
    logic [OW-1:0] inc;
    inc = cur + OW'(1);
    if (c.en) return inc & mask_of(c.lg);
    return inc;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      off_q <= '0;
      cfg_q <= '0;
    end else if (load) begin
      off_q <= '0;
      cfg_q <= cfg_in;
    end else if (step) begin
      off_q <= next_off(off_q, cfg_q);
    end
  end

  assign offset    = off_q;
  assign win_mask  = mask_of(cfg_q.lg);
  assign wrap_evt  = step && cfg_q.en && (off_q == win_mask);
  assign in_window = !cfg_q.en || (off_q <= win_mask);

endmodule

// File: rtl/dma_beat_counter.sv
module dma_beat_counter #(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [CW-1:0] bytes,
  input  logic          step,
  output logic [CW-1:0] remaining,
  output logic          pending,
  output logic          finished
);

  logic [CW-1:0] rem_q;
  logic          loaded_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rem_q    <= '0;
      loaded_q <= 1'b0;
    end else if (load) begin
      rem_q    <= bytes;
      loaded_q <= 1'b1;
    end else if (step) begin
      rem_q    <= rem_q - CW'(1);
    end
  end

  assign remaining = rem_q;
  assign pending   = loaded_q && (rem_q != '0);
  assign finished  = loaded_q && (rem_q == '0);

endmodule

// File: rtl/dma_addr_walker.sv
module dma_addr_walker
  import dma_hold_pkg::*;
#(
  parameter int AW   = 32,
  parameter int CW   = 16,
  parameter int SIDE = 0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ld_valid,
  input  logic [AW-1:0] ld_base,
  input  logic [CW-1:0] ld_bytes,
  input  logic [31:0]   mode_word,
  input  logic          beat_valid,
  output logic          beat_ready,
  output logic [AW-1:0] addr_out,
  output logic          done
);

  localparam int OW = CW;

  hold_cfg_t     cfg_dec;
  hold_cfg_t     cfg_q;
  logic [AW-1:0] base_q;
  logic [OW-1:0] offset;
  logic [OW-1:0] win_mask;
  logic [CW-1:0] remaining;
  logic          wrap_evt;
  logic          in_window;
  logic          pending;
  logic          fire;

  function automatic logic [AW-1:0] addr_of(input logic [AW-1:0] b,
                                            input logic [OW-1:0] o);
    return b + AW'(o);
  endfunction

  // A load takes priority over a beat offered in the same cycle.
  assign fire = beat_valid && pending && !ld_valid;

  dma_hold_decode #(.SIDE(SIDE)) u_dec (
    .mode_word (mode_word),
    .cfg       (cfg_dec)
  );

  dma_hold_offset #(.OW(OW)) u_off (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (ld_valid),
    .step      (fire),
    .cfg_in    (cfg_dec),
    .cfg_q     (cfg_q),
    .offset    (offset),
    .win_mask  (win_mask),
    .wrap_evt  (wrap_evt),
    .in_window (in_window)
  );

  dma_beat_counter #(.CW(CW)) u_cnt (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (ld_valid),
    .bytes     (ld_bytes),
    .step      (fire),
    .remaining (remaining),
    .pending   (pending),
    .finished  (done)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        base_q <= '0;
    else if (ld_valid) base_q <= ld_base;
  end

  assign addr_out   = addr_of(base_q, offset);
  assign beat_ready = pending;

endmodule

// File: rtl/dma_addr_walker_chk.sv
module dma_addr_walker_chk
  import dma_hold_pkg::*;
#(
  parameter int AW = 32,
  parameter int CW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          ld_valid,
  input logic [AW-1:0] ld_base,
  input logic          beat_valid,
  input logic          beat_ready,
  input logic [AW-1:0] addr_out,
  input logic          done,
  input logic          fire,
  input logic          wrap_evt,
  input logic          in_window,
  input logic [AW-1:0] base_q,
  input logic [CW-1:0] remaining,
  input hold_cfg_t     cfg_q
);

  p_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ld_valid |=> addr_out == $past(ld_base));

  p_stall_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!fire && !ld_valid) |=> $stable(addr_out));

  p_count_r7: assert property (@(posedge clk) disable iff (!rst_n)
    fire |=> remaining == $past(remaining) - CW'(1));

  p_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !ld_valid) |=> (done && $stable(addr_out)));

  p_wrap_r4: assert property (@(posedge clk) disable iff (!rst_n)
    wrap_evt |=> addr_out == base_q);

  p_window_r4: assert property (@(posedge clk) disable iff (!rst_n)
    in_window);

  p_cfg_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !ld_valid |=> $stable(cfg_q));

  p_fire_r6: assert property (@(posedge clk) disable iff (!rst_n)
    fire |-> (beat_valid && beat_ready));

endmodule

bind dma_addr_walker dma_addr_walker_chk #(.AW(AW), .CW(CW)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .ld_valid   (ld_valid),
  .ld_base    (ld_base),
  .beat_valid (beat_valid),
  .beat_ready (beat_ready),
  .addr_out   (addr_out),
  .done       (done),
  .fire       (fire),
  .wrap_evt   (wrap_evt),
  .in_window  (in_window),
  .base_q     (base_q),
  .remaining  (remaining),
  .cfg_q      (cfg_q)
);

// File: tb/tb_dma_addr_walker.sv
module tb_dma_addr_walker;

  localparam int AW = 32;
  localparam int CW = 16;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          ld_valid = 1'b0;
  logic [AW-1:0] ld_base = '0;
  logic [CW-1:0] ld_bytes = '0;
  logic [31:0]   mode_word = '0;
  logic          beat_valid = 1'b0;
  logic          rdy [2];
  logic          dn  [2];
  logic [AW-1:0] adr [2];

  int   n_checks = 0;
  int   n_fail   = 0;
  bit   cmp_en   = 0;
  string cur_req = "R1";

  // Behavioural reference state, one entry per side.
  longint unsigned m_base [2];
  longint unsigned m_off  [2];
  int              m_rem  [2];
  bit              m_ld   [2];
  bit              m_hen  [2];
  int              m_hsz  [2];

  always #10 clk = ~clk;

  dma_addr_walker #(.AW(AW), .CW(CW), .SIDE(0)) dut (
    .clk(clk), .rst_n(rst_n), .ld_valid(ld_valid), .ld_base(ld_base),
    .ld_bytes(ld_bytes), .mode_word(mode_word), .beat_valid(beat_valid),
    .beat_ready(rdy[0]), .addr_out(adr[0]), .done(dn[0]));

  dma_addr_walker #(.AW(AW), .CW(CW), .SIDE(1)) dut_dst (
    .clk(clk), .rst_n(rst_n), .ld_valid(ld_valid), .ld_base(ld_base),
    .ld_bytes(ld_bytes), .mode_word(mode_word), .beat_valid(beat_valid),
    .beat_ready(rdy[1]), .addr_out(adr[1]), .done(dn[1]));

  always @(posedge clk) begin
    for (int s = 0; s < 2; s++) begin
      if (!rst_n) begin
        m_base[s] = 0; m_off[s] = 0; m_rem[s] = 0; m_ld[s] = 0;
        m_hen[s] = 0; m_hsz[s] = 1;
      end else if (ld_valid) begin
        m_base[s] = ld_base;
        m_off[s]  = 0;
        m_rem[s]  = ld_bytes;
        m_ld[s]   = 1;
        m_hen[s]  = mode_word[12 + s];
        m_hsz[s]  = 1 << ((mode_word >> (14 + 2 * s)) & 3);
      end else if (beat_valid && m_ld[s] && m_rem[s] > 0) begin
        m_rem[s] = m_rem[s] - 1;
        if (m_hen[s]) m_off[s] = (m_off[s] + 1) % m_hsz[s];
        else          m_off[s] = m_off[s] + 1;
      end
    end
  end

  task automatic check(string req, string what, longint unsigned act, longint unsigned exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (cmp_en) begin
      for (int s = 0; s < 2; s++) begin
        longint unsigned ea;
        ea = (m_base[s] + m_off[s]) & 64'hFFFF_FFFF;
        check(cur_req, s == 0 ? "src addr" : "dst addr", adr[s], ea);
        check(cur_req, s == 0 ? "src ready" : "dst ready", rdy[s], (m_ld[s] && m_rem[s] > 0));
        check(cur_req, s == 0 ? "src done" : "dst done", dn[s], (m_ld[s] && m_rem[s] == 0));
      end
    end
  end

  task automatic load(input logic [AW-1:0] b, input int n, input logic [31:0] m);
    ld_valid = 1'b1; ld_base = b; ld_bytes = CW'(n); mode_word = m;
    @(negedge clk);
    ld_valid = 1'b0;
  endtask

  task automatic beats(input int n, input int gap);
    for (int i = 0; i < n; i++) begin
      beat_valid = (gap == 0) ? 1'b1 : ((i % (gap + 1)) == 0);
      @(negedge clk);
    end
    beat_valid = 1'b0;
  endtask

  int cyc = 0;
  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000) begin
      n_fail++;
      $display("FAIL watchdog: actual %0d expected < 20000 cycles", cyc);
      $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    // R1: reset state
    @(posedge clk); @(negedge clk);
    cmp_en = 1; cur_req = "R1";
    @(negedge clk); @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R3: linear stepping, extra beats past the end are ignored (R7)
    cur_req = "R3";
    load(32'h0000_1000, 6, 32'h0);
    cur_req = "R7";
    beats(9, 0);

    // R3: linear wrap across the top of the address space
    cur_req = "R3";
    load(32'hFFFF_FFFE, 4, 32'h0);
    beats(5, 0);

    // R4: src window 4, dst window 8, gapped beats (R6)
    cur_req = "R4";
    load(32'h0000_2002, 20, (32'd1 << 12) | (32'd2 << 14) | (32'd1 << 13) | (32'd3 << 16));
    cur_req = "R6";
    beats(12, 1);
    cur_req = "R4";
    beats(16, 0);

    // R5: window of one on both sides
    cur_req = "R5";
    load(32'h0000_4444, 5, (32'd1 << 12) | (32'd1 << 13));
    beats(7, 0);

    // R2: zero-length load is done at once
    cur_req = "R2";
    load(32'h0000_5000, 0, 32'h0);
    beats(3, 0);

    // R8: reload mid-window, then load with a beat in the same cycle
    cur_req = "R8";
    load(32'h0000_6000, 10, (32'd1 << 12) | (32'd1 << 14) | (32'd1 << 13) | (32'd2 << 16));
    beats(3, 0);
    load(32'h0000_7010, 10, (32'd1 << 12) | (32'd3 << 14) | (32'd1 << 13) | (32'd1 << 16));
    beat_valid = 1'b1;
    load(32'h0000_8020, 8, (32'd1 << 12) | (32'd2 << 14));
    beats(9, 0);

    // R9: mode word flips during a hold transfer
    cur_req = "R9";
    load(32'h0000_9000, 14, (32'd1 << 12) | (32'd1 << 14) | (32'd1 << 13) | (32'd2 << 16));
    for (int i = 0; i < 15; i++) begin
      mode_word = (i % 2 == 0) ? 32'hFFFF_FFFF : 32'h0;
      beat_valid = 1'b1;
      @(negedge clk);
    end
    beat_valid = 1'b0;

    // R10: side-specific bit positions, other bits set
    cur_req = "R10";
    load(32'h0000_A000, 12, 32'hFFFC_EFFF);
    beats(12, 0);
    load(32'h0000_B000, 12, 32'h0003_D000);
    beats(13, 2);

    @(negedge clk);
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end

endmodule